// File: doc/BRIEF.md
# USB Receive Endpoint Controller

This block keeps the control and status state of one non-zero OUT endpoint for a USB controller working as a peripheral. A processor reaches it through one 16-bit control/status word. That word is written in full and read back at any time. On the packet side, a protocol engine sends one strobe for each received OUT data packet. The strobe carries the packet's data PID parity and three error flags: CRC, bit-stuff and PID. The block then decides whether the packet is stored, dropped or refused. For bulk and interrupt traffic it returns a handshake code. For isochronous traffic it returns none.

Two packet slots are tracked in arrival order. A packet is released by an explicit clear, by a flush request, or automatically when a full packet's worth of bytes has been unloaded. The endpoint data toggle is kept here and advances on each accepted bulk packet. A DMA request follows the presence of a ready packet when it is enabled.

A three-state handshake machine sequences each packet:
- **IDLE**: waits for a packet strobe.
- **EVAL**: decides the outcome from the latched packet and the current state.
- **REPLY**: presents the handshake for one cycle.

The transitions are:
- IDLE→EVAL when a strobe arrives.
- EVAL→REPLY when a handshake is due.
- EVAL→IDLE when no handshake is due (isochronous, or corrupted bulk).
- REPLY→IDLE unconditionally.

Strobes that arrive outside IDLE are not taken.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, `hs_valid` is 0 and `dma_req` is 0.
- R2: The following bits read back the last value written:
  - bit 15, auto-release;
  - bit 14, isochronous select;
  - bit 13, DMA enable;
  - bit 12, NYET disable, shown only in bulk mode;
  - bit 11, DMA mode;
  - bit 5, stall request.

  Bits 10, 8, 7 and 4 always read 0.
- R3: Bit 9 reads the data toggle. Writing bit 9 changes the toggle only when bit 10 is 1 in the same write. Writing bit 7 as 1 forces the toggle to 0, and this takes priority over bit 10.
- R4: A bulk packet with no error, whose data PID parity equals the toggle and that finds a free slot, is stored. The toggle flips, bit 0 (packet ready) reads 1, and the handshake code is ACK = 0. The handshake appears on `hs_valid` for exactly one cycle, two clocks after the accepted strobe.
- R5: A bulk packet whose parity differs from the toggle gets ACK but is not stored, and the toggle is unchanged.
- R6: Bit 1 reads 1 exactly when both slots hold packets. A bulk packet arriving then gets NAK = 1 and is not stored.
- R7: A bulk packet that fills the last free slot gets NYET = 2 when `link_hs` is 1 and bit 12 is 0. Otherwise it gets ACK.
- R8: While bit 5 is 1, a bulk packet gets STALL = 3. Bit 6 then reads 1 and all stored packets are discarded. Bit 6 is cleared only by writing it as 0. In isochronous mode bit 5 has no effect.
- R9: A write with bit 0 equal to 0 while a packet is ready releases the oldest packet. Any next packet then becomes ready.
- R10: A write with bit 4 equal to 1 releases the oldest packet only when one is ready, and has no effect otherwise. Two such writes empty a full FIFO.
- R11: With bit 15 set, the unload strobe that completes MAXP bytes of the ready packet releases that packet. With bit 15 clear, unloading never releases a packet.
- R12: Bit 2 (overrun) and bit 3 (data error) behave as follows:
  - Isochronous packets get no handshake.
  - A CRC or bit-stuff error sets bit 3 for that packet while it is ready.
  - A PID error shows in bit 12 while that packet is ready.
  - A packet that finds both slots full sets bit 2, which stays set until bit 2 is written 0.
  - In bulk mode bits 3 and 2 read 0.
  - A corrupted bulk packet gets no handshake and is not stored.
- R13: `dma_req` is 1 exactly when bit 13 and bit 0 both read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write value |
| csr_rdata | output | 16 | Control word read value |
| pkt_stb | input | 1 | One-cycle strobe: an OUT data packet was received |
| pkt_data1 | input | 1 | Data PID parity of the packet (1 = DATA1) |
| pkt_crc_err | input | 1 | Packet had a CRC error |
| pkt_stuff_err | input | 1 | Packet had a bit-stuff error |
| pkt_pid_err | input | 1 | Packet had a PID error |
| link_hs | input | 1 | Link runs at high speed |
| unload_stb | input | 1 | One byte unloaded from the ready packet |
| hs_valid | output | 1 | Handshake code valid |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 NYET, 3 STALL |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with two slots and a maximum packet size of 8 bytes. With that size, the auto-release point is reached after a short burst of unload strobes. Both its exact boundary (7 strobes hold, the 8th releases) and the no-release case under a full count stay cheap to reach. Two slots let one packet sequence fill the FIFO, so the NYET, NAK, overrun and double-flush paths are covered. A behavioural model of the same endpoint is compared against every output on every clock.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_NYET  = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_REPLY = 2'd2
    } ep_state_e;

    typedef struct packed {
        logic crc_bad;
        logic pid_bad;
    } slot_flags_t;

    localparam int B_AUTO_REL   = 15;
    localparam int B_ISO        = 14;
    localparam int B_DMA_EN     = 13;
    localparam int B_NO_NYET    = 12;
    localparam int B_DMA_MODE   = 11;
    localparam int B_TOG_WE     = 10;
    localparam int B_TOG        = 9;
    localparam int B_TOG_CLR    = 7;
    localparam int B_STALL_DONE = 6;
    localparam int B_STALL_REQ  = 5;
    localparam int B_FLUSH      = 4;
    localparam int B_DATA_ERR   = 3;
    localparam int B_OVERRUN    = 2;
    localparam int B_FULL       = 1;
    localparam int B_READY      = 0;

endpackage

// File: rtl/rxep_slot_queue.sv
module rxep_slot_queue
    import usb_rxep_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int OCC_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  slot_flags_t       push_flags,
    input  logic              pop,
    input  logic              flush_all,
    output logic [OCC_W-1:0]  occ,
    output slot_flags_t       head_flags,
    output logic              full,
    output logic              ready
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    slot_flags_t         slot_q [SLOTS];
    logic [OCC_W-1:0]    occ_q;
    logic [OCC_W-1:0]    wr_pos;
    logic [OCC_W-1:0]    occ_next;

    always_comb begin
        wr_pos   = pop ? (occ_q - OCC_W'(1)) : occ_q;
        occ_next = occ_q + OCC_W'(push) - OCC_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (flush_all) begin
            occ_q <= '0;
        end else begin
            if (pop) begin
                for (int i = 0; i < SLOTS - 1; i++) slot_q[i] <= slot_q[i+1];
            end
            if (push) slot_q[wr_pos[IDX_W-1:0]] <= push_flags;
            occ_q <= occ_next;
        end
    end

    assign occ        = occ_q;
    assign head_flags = slot_q[0];
    assign full       = (occ_q == OCC_W'(SLOTS));
    assign ready      = (occ_q != '0);

endmodule

// File: rtl/rxep_toggle.sv
module rxep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic load_val,
    input  logic flip,
    output logic tog
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     tog_q <= 1'b0;
        else if (clr)   tog_q <= 1'b0;
        else if (load)  tog_q <= load_val;
        else if (flip)  tog_q <= ~tog_q;
    end

    assign tog = tog_q;

endmodule

// File: rtl/rxep_hs_fsm.sv
module rxep_hs_fsm
    import usb_rxep_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int OCC_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_stb,
    input  logic             pkt_data1,
    input  logic             pkt_crc_err,
    input  logic             pkt_stuff_err,
    input  logic             pkt_pid_err,
    input  logic             iso,
    input  logic             stall_req,
    input  logic             no_nyet,
    input  logic             link_hs,
    input  logic             tog,
    input  logic [OCC_W-1:0] occ,
    input  logic             full,
    output logic             push,
    output slot_flags_t      push_flags,
    output logic             flip,
    output logic             stall_evt,
    output logic             ovr_evt,
    output logic             hs_valid,
    output hs_code_e         hs_code
);
    ep_state_e state_q, state_d;
    logic      lp_data1, lp_crc, lp_stuff, lp_pid;
    hs_code_e  code_q, code_d;
    logic      reply_due;
    logic      bad;

    assign bad = lp_crc | lp_stuff;

    // decision and next state
    always_comb begin
        state_d    = state_q;
        code_d     = code_q;
        reply_due  = 1'b0;
        push       = 1'b0;
        push_flags = '0;
        flip       = 1'b0;
        stall_evt  = 1'b0;
        ovr_evt    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pkt_stb) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (iso) begin
                    if (full) begin
                        ovr_evt = 1'b1;
                    end else begin
                        push               = 1'b1;
                        push_flags.crc_bad = bad;
                        push_flags.pid_bad = lp_pid;
                    end
                end else if (bad || lp_pid) begin
                    reply_due = 1'b0;
                end else if (stall_req) begin
                    stall_evt = 1'b1;
                    reply_due = 1'b1;
                    code_d    = HS_STALL;
                end else if (full) begin
                    reply_due = 1'b1;
                    code_d    = HS_NAK;
                end else if (lp_data1 != tog) begin
                    reply_due = 1'b1;
                    code_d    = HS_ACK;
                end else begin
                    push      = 1'b1;
                    flip      = 1'b1;
                    reply_due = 1'b1;
                    if ((occ + OCC_W'(1) == OCC_W'(SLOTS)) && link_hs && !no_nyet)
                        code_d = HS_NYET;
                    else
                        code_d = HS_ACK;
                end
                state_d = reply_due ? ST_REPLY : ST_IDLE;
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // packet latch and handshake code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_data1 <= 1'b0;
            lp_crc   <= 1'b0;
            lp_stuff <= 1'b0;
            lp_pid   <= 1'b0;
            code_q   <= HS_ACK;
        end else begin
            if (state_q == ST_IDLE && pkt_stb) begin
                lp_data1 <= pkt_data1;
                lp_crc   <= pkt_crc_err;
                lp_stuff <= pkt_stuff_err;
                lp_pid   <= pkt_pid_err;
            end
            code_q <= code_d;
        end
    end

    // outputs
    always_comb begin
        hs_valid = (state_q == ST_REPLY);
        hs_code  = code_q;
    end

endmodule

// File: rtl/rxep_csr.sv
module rxep_csr
    import usb_rxep_pkg::*;
#(
    parameter int MAXP  = 64,
    parameter int CNT_W = $clog2(MAXP + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [15:0] csr_wdata,
    input  logic        unload_stb,
    input  logic        ready,
    input  logic        full,
    input  slot_flags_t head_flags,
    input  logic        tog,
    input  logic        stall_evt,
    input  logic        ovr_evt,
    output logic [15:0] csr_rdata,
    output logic        pop,
    output logic        tog_clr,
    output logic        tog_load,
    output logic        tog_val,
    output logic        iso,
    output logic        stall_req,
    output logic        no_nyet,
    output logic        dma_req
);
    logic             auto_rel_q, iso_q, dma_en_q, no_nyet_q, dma_mode_q;
    logic             stall_req_q, stall_done_q, ovr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             auto_pop, cpu_pop, cnt_inc;

    assign auto_pop = unload_stb && ready && auto_rel_q && (cnt_q == CNT_W'(MAXP - 1));
    assign cpu_pop  = csr_we && (!csr_wdata[B_READY] || csr_wdata[B_FLUSH]);
    assign pop      = ready && (cpu_pop || auto_pop);
    assign cnt_inc  = unload_stb && ready && (cnt_q != CNT_W'(MAXP));

    assign tog_clr  = csr_we && csr_wdata[B_TOG_CLR];
    assign tog_load = csr_we && csr_wdata[B_TOG_WE];
    assign tog_val  = csr_wdata[B_TOG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_rel_q   <= 1'b0;
            iso_q        <= 1'b0;
            dma_en_q     <= 1'b0;
            no_nyet_q    <= 1'b0;
            dma_mode_q   <= 1'b0;
            stall_req_q  <= 1'b0;
        end else if (csr_we) begin
            auto_rel_q   <= csr_wdata[B_AUTO_REL];
            iso_q        <= csr_wdata[B_ISO];
            dma_en_q     <= csr_wdata[B_DMA_EN];
            no_nyet_q    <= csr_wdata[B_NO_NYET];
            dma_mode_q   <= csr_wdata[B_DMA_MODE];
            stall_req_q  <= csr_wdata[B_STALL_REQ];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_done_q <= 1'b0;
            ovr_q        <= 1'b0;
        end else begin
            if (stall_evt)                                stall_done_q <= 1'b1;
            else if (csr_we && !csr_wdata[B_STALL_DONE])  stall_done_q <= 1'b0;
            if (ovr_evt)                                  ovr_q <= 1'b1;
            else if (csr_we && !csr_wdata[B_OVERRUN])     ovr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (pop || stall_evt)  cnt_q <= '0;
        else if (cnt_inc)           cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        csr_rdata               = '0;
        csr_rdata[B_AUTO_REL]   = auto_rel_q;
        csr_rdata[B_ISO]        = iso_q;
        csr_rdata[B_DMA_EN]     = dma_en_q;
        csr_rdata[B_NO_NYET]    = iso_q ? (ready && head_flags.pid_bad) : no_nyet_q;
        csr_rdata[B_DMA_MODE]   = dma_mode_q;
        csr_rdata[B_TOG]        = tog;
        csr_rdata[B_STALL_DONE] = stall_done_q;
        csr_rdata[B_STALL_REQ]  = stall_req_q;
        csr_rdata[B_DATA_ERR]   = iso_q && ready && head_flags.crc_bad;
        csr_rdata[B_OVERRUN]    = iso_q && ovr_q;
        csr_rdata[B_FULL]       = full;
        csr_rdata[B_READY]      = ready;
    end

    assign iso       = iso_q;
    assign stall_req = stall_req_q;
    assign no_nyet   = no_nyet_q;
    assign dma_req   = dma_en_q && ready;

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
    import usb_rxep_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int MAXP  = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [15:0] csr_wdata,
    output logic [15:0] csr_rdata,
    input  logic        pkt_stb,
    input  logic        pkt_data1,
    input  logic        pkt_crc_err,
    input  logic        pkt_stuff_err,
    input  logic        pkt_pid_err,
    input  logic        link_hs,
    input  logic        unload_stb,
    output logic        hs_valid,
    output logic [1:0]  hs_code,
    output logic        dma_req
);
    localparam int OCC_W = $clog2(SLOTS + 1);
    localparam int CNT_W = $clog2(MAXP + 1);

    logic             q_push, q_pop, q_full, q_ready, stall_evt, ovr_evt, flip;
    slot_flags_t      q_push_flags, q_head;
    logic [OCC_W-1:0] q_occ;
    logic             tog, tog_clr, tog_load, tog_val;
    logic             iso, stall_req, no_nyet;
    hs_code_e         hs_code_e_w;

    rxep_slot_queue #(.SLOTS(SLOTS), .OCC_W(OCC_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .push_flags (q_push_flags),
        .pop        (q_pop),
        .flush_all  (stall_evt),
        .occ        (q_occ),
        .head_flags (q_head),
        .full       (q_full),
        .ready      (q_ready)
    );

    rxep_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tog_clr),
        .load     (tog_load),
        .load_val (tog_val),
        .flip     (flip),
        .tog      (tog)
    );

    rxep_hs_fsm #(.SLOTS(SLOTS), .OCC_W(OCC_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_stb       (pkt_stb),
        .pkt_data1     (pkt_data1),
        .pkt_crc_err   (pkt_crc_err),
        .pkt_stuff_err (pkt_stuff_err),
        .pkt_pid_err   (pkt_pid_err),
        .iso           (iso),
        .stall_req     (stall_req),
        .no_nyet       (no_nyet),
        .link_hs       (link_hs),
        .tog           (tog),
        .occ           (q_occ),
        .full          (q_full),
        .push          (q_push),
        .push_flags    (q_push_flags),
        .flip          (flip),
        .stall_evt     (stall_evt),
        .ovr_evt       (ovr_evt),
        .hs_valid      (hs_valid),
        .hs_code       (hs_code_e_w)
    );

    rxep_csr #(.MAXP(MAXP), .CNT_W(CNT_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_we     (csr_we),
        .csr_wdata  (csr_wdata),
        .unload_stb (unload_stb),
        .ready      (q_ready),
        .full       (q_full),
        .head_flags (q_head),
        .tog        (tog),
        .stall_evt  (stall_evt),
        .ovr_evt    (ovr_evt),
        .csr_rdata  (csr_rdata),
        .pop        (q_pop),
        .tog_clr    (tog_clr),
        .tog_load   (tog_load),
        .tog_val    (tog_val),
        .iso        (iso),
        .stall_req  (stall_req),
        .no_nyet    (no_nyet),
        .dma_req    (dma_req)
    );

    assign hs_code = hs_code_e_w;

endmodule

// File: rtl/rxep_chk.sv
module rxep_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hs_valid,
    input logic [1:0]  hs_code,
    input logic [15:0] csr_rdata,
    input logic        dma_req,
    input logic        q_push,
    input logic        q_full
);
    // R4
    hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    // R8
    stall_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd3) |-> (csr_rdata[6] && !csr_rdata[0]));

    // R12
    bulk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[14] |-> (csr_rdata[3:2] == 2'b00));

    // R6
    full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[1] |-> csr_rdata[0]);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !q_full);

    // R13
    dma_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (csr_rdata[0] && csr_rdata[13]));

endmodule

bind usb_rx_ep_ctrl rxep_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .csr_rdata (csr_rdata),
    .dma_req   (dma_req),
    .q_push    (q_push),
    .q_full    (q_full)
);

// File: tb/sim_usb_rx_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_rx_ep_ctrl;
    localparam int SLOTS = 2;
    localparam int MAXP  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic        pkt_stb = 1'b0, pkt_data1 = 1'b0;
    logic        pkt_crc_err = 1'b0, pkt_stuff_err = 1'b0, pkt_pid_err = 1'b0;
    logic        link_hs = 1'b1;
    logic        unload_stb = 1'b0;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        dma_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [2:0] last_hs;

    always #4 clk = ~clk;

    usb_rx_ep_ctrl #(.SLOTS(SLOTS), .MAXP(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .pkt_stb(pkt_stb), .pkt_data1(pkt_data1),
        .pkt_crc_err(pkt_crc_err), .pkt_stuff_err(pkt_stuff_err),
        .pkt_pid_err(pkt_pid_err), .link_hs(link_hs), .unload_stb(unload_stb),
        .hs_valid(hs_valid), .hs_code(hs_code), .dma_req(dma_req)
    );

    // ---------------- behavioural reference model ----------------
    int m_state = 0;
    bit lp_d1, lp_bad, lp_pid;
    int m_code = 0;
    int q[$];
    bit ac, iso, dmaen, nonyet, dmamode, sreq, sdone, ovr, tog;
    int cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_code = 0; q.delete(); cnt = 0;
            ac = 0; iso = 0; dmaen = 0; nonyet = 0; dmamode = 0;
            sreq = 0; sdone = 0; ovr = 0; tog = 0;
        end else begin
            automatic bit rdy = q.size() > 0;
            automatic bit full = q.size() == SLOTS;
            automatic bit push = 0, flip = 0, stl = 0, ovev = 0, reply = 0, pop;
            automatic int pf = 0;
            automatic int nstate = 0;
            if (m_state == 1) begin
                if (iso) begin
                    if (full) ovev = 1;
                    else begin push = 1; pf = (lp_bad ? 1 : 0) + (lp_pid ? 2 : 0); end
                end else if (lp_bad || lp_pid) begin
                    reply = 0;
                end else if (sreq) begin
                    stl = 1; reply = 1; m_code = 3;
                end else if (full) begin
                    reply = 1; m_code = 1;
                end else if (lp_d1 != tog) begin
                    reply = 1; m_code = 0;
                end else begin
                    push = 1; flip = 1; reply = 1;
                    m_code = (q.size() + 1 == SLOTS && link_hs && !nonyet) ? 2 : 0;
                end
                nstate = reply ? 2 : 0;
            end else if (m_state == 0 && pkt_stb) begin
                nstate = 1;
                lp_d1 = pkt_data1; lp_bad = pkt_crc_err | pkt_stuff_err; lp_pid = pkt_pid_err;
            end
            pop = rdy && ((csr_we && (!csr_wdata[0] || csr_wdata[4])) ||
                          (unload_stb && ac && cnt == MAXP - 1));
            if (pop || stl) cnt = 0;
            else if (unload_stb && rdy && cnt != MAXP) cnt++;
            if (stl) q.delete();
            else begin
                if (pop) void'(q.pop_front());
                if (push) q.push_back(pf);
            end
            if (csr_we && csr_wdata[7]) tog = 0;
            else if (csr_we && csr_wdata[10]) tog = csr_wdata[9];
            else if (flip) tog = !tog;
            if (stl) sdone = 1; else if (csr_we && !csr_wdata[6]) sdone = 0;
            if (ovev) ovr = 1; else if (csr_we && !csr_wdata[2]) ovr = 0;
            if (csr_we) begin
                ac = csr_wdata[15]; iso = csr_wdata[14]; dmaen = csr_wdata[13];
                nonyet = csr_wdata[12]; dmamode = csr_wdata[11]; sreq = csr_wdata[5];
            end
            m_state = nstate;
        end
    end

    function automatic logic [15:0] model_rd();
        logic [15:0] r = '0;
        bit rdy = q.size() > 0;
        int head = rdy ? q[0] : 0;
        r[15] = ac; r[14] = iso; r[13] = dmaen;
        r[12] = iso ? (rdy && head[1]) : nonyet;
        r[11] = dmamode; r[9] = tog; r[6] = sdone; r[5] = sreq;
        r[3] = iso && rdy && head[0];
        r[2] = iso && ovr;
        r[1] = q.size() == SLOTS;
        r[0] = rdy;
        return r;
    endfunction

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (csr_rdata !== model_rd()) begin
                errors++;
                $display("FAIL R2 R3 R9 R10 R11 R12 model csr: actual %h expected %h", csr_rdata, model_rd());
            end
            checks++;
            if (hs_valid !== (m_state == 2) || (hs_valid && hs_code !== 2'(m_code))) begin
                errors++;
                $display("FAIL R4 R5 R6 R7 R8 model handshake: actual %b/%0d expected %b/%0d",
                         hs_valid, hs_code, m_state == 2, m_code);
            end
            checks++;
            if (dma_req !== (dmaen && q.size() > 0)) begin
                errors++;
                $display("FAIL R13 model dma_req: actual %b expected %b", dma_req, dmaen && q.size() > 0);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic send(input bit d1, input bit crc, input bit stuff, input bit pid);
        pkt_stb = 1'b1; pkt_data1 = d1; pkt_crc_err = crc; pkt_stuff_err = stuff; pkt_pid_err = pid;
        @(negedge clk);
        pkt_stb = 1'b0; pkt_crc_err = 1'b0; pkt_stuff_err = 1'b0; pkt_pid_err = 1'b0;
        @(negedge clk);
        last_hs = {hs_valid, hs_code};
        @(negedge clk);
    endtask

    task automatic unl(input int n);
        for (int i = 0; i < n; i++) begin
            unload_stb = 1'b1;
            @(negedge clk);
        end
        unload_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset csr", csr_rdata, 16'h0000);
        chk("R1 reset outputs", {14'd0, hs_valid, dma_req}, 16'h0000);

        wr(16'hF8FF); chk("R2 field readback", csr_rdata, 16'hE820);
        wr(16'h1000); chk("R2 no-nyet readback", csr_rdata, 16'h1000);
        wr(16'h0000); chk("R2 cleared", csr_rdata, 16'h0000);

        wr(16'h0201); chk("R3 toggle write ignored without enable", csr_rdata, 16'h0000);
        wr(16'h0601); chk("R3 toggle written with enable", csr_rdata, 16'h0200);
        wr(16'h0681); chk("R3 clear beats enable", csr_rdata, 16'h0000);

        send(0, 0, 0, 0); chk("R4 ACK", {13'd0, last_hs}, 16'h0004);
        chk("R4 stored, toggle flipped", csr_rdata, 16'h0201);
        send(0, 0, 0, 0); chk("R5 mismatch ACK", {13'd0, last_hs}, 16'h0004);
        chk("R5 not stored", csr_rdata, 16'h0201);
        send(1, 0, 0, 0); chk("R7 NYET on fill", {13'd0, last_hs}, 16'h0006);
        chk("R6 full flag", csr_rdata, 16'h0003);
        send(0, 0, 0, 0); chk("R6 NAK when full", {13'd0, last_hs}, 16'h0005);
        chk("R6 not stored", csr_rdata, 16'h0003);

        wr(16'h2001); chk("R13 dma_req", {15'd0, dma_req}, 16'h0001);
        wr(16'h2011); chk("R10 first flush", csr_rdata, 16'h2001);
        wr(16'h2011); chk("R10 second flush", csr_rdata, 16'h2000);
        chk("R13 dma_req drops", {15'd0, dma_req}, 16'h0000);
        wr(16'h2011); chk("R10 flush ignored when empty", csr_rdata, 16'h2000);
        wr(16'h0000);

        wr(16'h1000);
        send(0, 0, 0, 0);
        send(1, 0, 0, 0); chk("R7 no-nyet gives ACK on fill", {13'd0, last_hs}, 16'h0004);
        chk("R7 full", csr_rdata, 16'h1003);
        wr(16'h1000); chk("R9 clear releases oldest", csr_rdata, 16'h1001);
        wr(16'h1000); chk("R9 second clear", csr_rdata, 16'h1000);

        wr(16'h8000);
        send(0, 0, 0, 0); chk("R11 ready", csr_rdata, 16'h8201);
        unl(7); chk("R11 held before MAXP", csr_rdata, 16'h8201);
        unl(1); chk("R11 auto release at MAXP", csr_rdata, 16'h8200);
        wr(16'h0001);
        send(1, 0, 0, 0);
        unl(8); chk("R11 no release without auto", csr_rdata, 16'h0001);
        wr(16'h0000); chk("R9 clear", csr_rdata, 16'h0000);

        send(0, 0, 0, 0);
        wr(16'h0021); chk("R8 stall armed", csr_rdata, 16'h0221);
        send(1, 0, 0, 0); chk("R8 STALL code", {13'd0, last_hs}, 16'h0007);
        chk("R8 sent flag, flushed", csr_rdata, 16'h0260);
        wr(16'h0040); chk("R8 sent flag kept by writing 1", csr_rdata, 16'h0240);
        wr(16'h0000); chk("R8 sent flag cleared", csr_rdata, 16'h0200);
        send(1, 0, 0, 0);
        wr(16'h0000);

        send(0, 1, 0, 0); chk("R12 bulk error silent", {13'd0, last_hs}, 16'h0000);
        chk("R12 bulk error not stored", csr_rdata, 16'h0000);

        wr(16'h4000);
        send(0, 1, 0, 0); chk("R12 iso no handshake", {13'd0, last_hs}, 16'h0000);
        chk("R12 data error", csr_rdata, 16'h4009);
        send(0, 0, 0, 1); chk("R12 second stored", csr_rdata, 16'h400B);
        send(0, 0, 1, 0); chk("R12 overrun", csr_rdata, 16'h400F);
        wr(16'h4001); chk("R12 overrun cleared", csr_rdata, 16'h400B);
        wr(16'h4000); chk("R12 pid error shown", csr_rdata, 16'h5001);
        wr(16'h4000);
        wr(16'h4020);
        send(0, 0, 0, 0); chk("R8 stall ignored in iso", {13'd0, last_hs}, 16'h0000);
        chk("R8 iso stored under stall", csr_rdata, 16'h4021);
        send(1, 1, 0, 0);
        send(0, 0, 0, 0); chk("R12 overrun again", csr_rdata, 16'h4027);
        wr(16'h0025); chk("R12 bulk masks overrun", csr_rdata, 16'h0023);
        wr(16'h4025); chk("R12 overrun kept", csr_rdata, 16'h4027);
        wr(16'h0000); chk("R12 bulk masks data error", csr_rdata, 16'h0001);
        wr(16'h0000);

        link_hs = 1'b0;
        send(0, 0, 0, 0);
        send(1, 0, 0, 0); chk("R7 full speed ACK on fill", {13'd0, last_hs}, 16'h0004);
        wr(16'h0010); wr(16'h0010); chk("R10 emptied", csr_rdata, 16'h0000);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule